// File: doc/BRIEF.md
# Receiver Input Formatter with Exponent Scaling

This block sits at the front of a digital receive path. It takes 16-bit parallel converter words, each optionally paired with a 3-bit exponent, and hands a normalized 23-bit sample stream to the downstream mixer. Data from gain-ranging or floating-point converters is restored to one common fixed-point scale. The mantissa is placed at the top of the 23-bit word and then shifted right arithmetically by an amount set by the exponent.

Three input formats are supported. In single-channel real, every word is one sample. In two-channel real, two channels alternate on one bus and a channel-select input tags each sample. In complex, I and Q arrive on consecutive words and leave together as one pair. The format and scaling settings are taken into the block only while reset is held or while the block is idle, so a settings change can never split an I/Q pair.

Top module: `rx_input_formatter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `out_valid`, `out_i`, `out_q` and `out_tag` all at zero.
- R2: In format 0 (single real), or in the unused format 3, each accepted word gives `out_valid` high in the following cycle, with `out_q` = 0 and `out_tag` = 0.
- R3: The scaled value is the 16-bit mantissa followed by seven zero bits, read as a signed 23-bit number and shifted right arithmetically by `s`. Here `s` = offset − e, forced to 0 when e exceeds the offset. For example, 0x8000 with s = 0 gives 0x400000, and 0x0100 with s = 7 gives 0x000100.
- R4: When the exponent enable is low, e is taken as 0, so the shift equals the offset.
- R5: When the invert setting is high (and the exponent is enabled), e is 7 minus the exponent input.
- R6: In format 1 (two-channel real), each accepted word gives one output. `out_tag` equals `in_chan` as sampled with that word, and `out_q` = 0.
- R7: In format 2 (complex), a word with `in_chan` = 0 is held as I. The next word with `in_chan` = 1 is Q, and it causes exactly one `out_valid` pulse carrying both values, with `out_tag` = 0.
- R8: In format 2, a Q word with no I held produces no output. A second I word replaces the held one.
- R9: The configuration inputs take effect only at an edge where `rst_n` is low, or where `in_valid` is low and no I word is held. A change made while an I word is held is deferred.
- R10: `out_valid` is high for exactly one cycle per output, and only in the cycle after an accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fmt | input | 2 | Format: 0 real, 1 two-channel real, 2 complex, 3 treated as real |
| cfg_exp_en | input | 1 | Use the exponent input for scaling |
| cfg_exp_inv | input | 1 | Invert exponent polarity (7 − exponent) |
| cfg_exp_off | input | 3 | Shift offset from which the exponent is subtracted |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 16 | Signed mantissa |
| in_exp | input | 3 | Exponent accompanying the word |
| in_chan | input | 1 | Channel select: B in two-channel mode, Q in complex mode |
| out_valid | output | 1 | One-cycle output strobe |
| out_i | output | 23 | Scaled real or I sample |
| out_q | output | 23 | Scaled Q sample, zero in real formats |
| out_tag | output | 1 | Channel tag in two-channel mode |

## Verification
The assertions assume that `in_valid` and `in_chan` carry known values once reset is released. They also assume that the complex format is fed I before Q, although an orphan Q is still tolerated and checked for being dropped. The stimulus changes the configuration only at falling edges and keeps every input defined. It deliberately changes the configuration while an I word is held, so that the deferral rule is exercised rather than avoided.

// File: rtl/rxif_pkg.sv
// Package: shared format encoding for the receiver input formatter.
// Assumes: the encodings are fixed; value 3 is reserved and behaves as real.
package rxif_pkg;
    typedef enum logic [1:0] {
        FMT_REAL = 2'd0,
        FMT_DUAL = 2'd1,
        FMT_CPLX = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;
endpackage

// File: rtl/rxif_cfg_hold.sv
// Module: holds the active configuration.
// It loads the configuration during reset or when the block reports idle.
// Assumes: the caller derives idle from "no input word and no held I word".
module rxif_cfg_hold #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic [1:0]       cfg_fmt,
    input  logic             cfg_exp_en,
    input  logic             cfg_exp_inv,
    input  logic [EXP_W-1:0] cfg_exp_off,
    output rxif_pkg::fmt_e   act_fmt,
    output logic             act_exp_en,
    output logic             act_exp_inv,
    output logic [EXP_W-1:0] act_exp_off
);
    // Purpose: sample the configuration inputs only at safe points.
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            act_fmt     <= rxif_pkg::fmt_e'(cfg_fmt);
            act_exp_en  <= cfg_exp_en;
            act_exp_inv <= cfg_exp_inv;
            act_exp_off <= cfg_exp_off;
        end
    end
endmodule

// File: rtl/rxif_exp_scaler.sv
// Module: combinational exponent scaler.
// It left-justifies the mantissa into OUT_W bits and shifts it right
// arithmetically by (offset - effective exponent), floored at zero.
// Assumes: OUT_W = DATA_W + 2**EXP_W - 1, so no bit is lost.
module rxif_exp_scaler #(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 3,
    parameter int OUT_W  = DATA_W + (1 << EXP_W) - 1
) (
    input  logic [DATA_W-1:0] mant,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic              exp_en,
    input  logic              exp_inv,
    input  logic [EXP_W-1:0]  exp_off,
    output logic [OUT_W-1:0]  scaled
);
    localparam int PAD_W = OUT_W - DATA_W;

    logic [EXP_W-1:0] e_eff;
    logic [EXP_W-1:0] shamt;
    logic [OUT_W-1:0] stage [0:EXP_W];

    // Purpose: resolve the exponent polarity and the bypass.
    always_comb begin
        if (!exp_en)
            e_eff = '0;
        else if (exp_inv)
            e_eff = ~exp_in;
        else
            e_eff = exp_in;
    end

    // Purpose: shift amount, floored at zero when the exponent exceeds the offset.
    always_comb begin
        if (exp_off >= e_eff)
            shamt = exp_off - e_eff;
        else
            shamt = '0;
    end

    // Purpose: place the mantissa at the top of the output word.
    always_comb begin
        stage[0] = {mant, {PAD_W{1'b0}}};
    end

    // One arithmetic shift stage per bit of the shift amount.
    for (genvar k = 0; k < EXP_W; k++) begin : g_shift
        always_comb begin
            if (shamt[k])
                stage[k+1] = OUT_W'($signed(stage[k]) >>> (1 << k));
            else
                stage[k+1] = stage[k];
        end
    end

    // Purpose: drive the final stage out.
    always_comb begin
        scaled = stage[EXP_W];
    end
endmodule

// File: rtl/rxif_pair_unit.sv
// Module: routes scaled words into output samples according to the format.
// It holds an I word in complex format until its Q word arrives.
// Assumes: the format input does not change while an I word is held.
module rxif_pair_unit #(
    parameter int OUT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rxif_pkg::fmt_e   fmt,
    input  logic             in_valid,
    input  logic             in_chan,
    input  logic [OUT_W-1:0] smp,
    output logic             pend,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_i,
    output logic [OUT_W-1:0] out_q,
    output logic             out_tag
);
    logic [OUT_W-1:0] hold_i;

    // Purpose: output register, I holding register and pairing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            hold_i    <= '0;
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            out_tag   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                case (fmt)
                    rxif_pkg::FMT_CPLX: begin
                        if (!in_chan) begin
                            pend   <= 1'b1;
                            hold_i <= smp;
                        end else if (pend) begin
                            pend      <= 1'b0;
                            out_valid <= 1'b1;
                            out_i     <= hold_i;
                            out_q     <= smp;
                            out_tag   <= 1'b0;
                        end
                    end
                    rxif_pkg::FMT_DUAL: begin
                        out_valid <= 1'b1;
                        out_i     <= smp;
                        out_q     <= '0;
                        out_tag   <= in_chan;
                    end
                    default: begin
                        out_valid <= 1'b1;
                        out_i     <= smp;
                        out_q     <= '0;
                        out_tag   <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_input_formatter.sv
// Module: top level of the receiver input formatter.
// It joins the configuration hold, the exponent scaler and the pairing unit.
// Assumes: synchronous active-low reset; one word per clock at most.
module rx_input_formatter #(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 3,
    parameter int OUT_W  = DATA_W + (1 << EXP_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_exp_en,
    input  logic              cfg_exp_inv,
    input  logic [EXP_W-1:0]  cfg_exp_off,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic              in_chan,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q,
    output logic              out_tag
);
    rxif_pkg::fmt_e   act_fmt;
    logic             act_exp_en;
    logic             act_exp_inv;
    logic [EXP_W-1:0] act_exp_off;
    logic             pend;
    logic             idle;
    logic [OUT_W-1:0] smp;

    // Purpose: the block is idle with no word arriving and no I word held.
    always_comb begin
        idle = !in_valid && !pend;
    end

    rxif_cfg_hold #(.EXP_W(EXP_W)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .cfg_fmt    (cfg_fmt),
        .cfg_exp_en (cfg_exp_en),
        .cfg_exp_inv(cfg_exp_inv),
        .cfg_exp_off(cfg_exp_off),
        .act_fmt    (act_fmt),
        .act_exp_en (act_exp_en),
        .act_exp_inv(act_exp_inv),
        .act_exp_off(act_exp_off)
    );

    rxif_exp_scaler #(.DATA_W(DATA_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) scl_i (
        .mant   (in_data),
        .exp_in (in_exp),
        .exp_en (act_exp_en),
        .exp_inv(act_exp_inv),
        .exp_off(act_exp_off),
        .scaled (smp)
    );

    rxif_pair_unit #(.OUT_W(OUT_W)) pair_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (act_fmt),
        .in_valid (in_valid),
        .in_chan  (in_chan),
        .smp      (smp),
        .pend     (pend),
        .out_valid(out_valid),
        .out_i    (out_i),
        .out_q    (out_q),
        .out_tag  (out_tag)
    );
endmodule

// File: rtl/rxif_checker.sv
// Module: assertion checker for the receiver input formatter, bound to the top.
// Assumes: in_valid and in_chan are known after reset.
module rxif_checker #(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_chan,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_i,
    input logic [OUT_W-1:0]  out_q,
    input logic              out_tag,
    input logic [1:0]        act_fmt,
    input logic              act_exp_en,
    input logic [2:0]        act_exp_off,
    input logic              pend
);
    localparam int PAD_W = OUT_W - DATA_W;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0 && !out_tag));

    assert_valid_follows_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_real_q_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_fmt != 2'd2) |-> out_q == '0);

    assert_unshifted_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_fmt != 2'd2 && !act_exp_en && act_exp_off == 3'd0)
        |-> out_i == {$past(in_data), {PAD_W{1'b0}}});

    assert_tag_only_dual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_fmt != 2'd1) |-> !out_tag);

    assert_pair_on_q_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_fmt == 2'd2) |-> $past(in_chan));

    assert_orphan_q_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(in_chan) && !$past(pend)
         && $past(act_fmt) == 2'd2) |-> !out_valid);

    assert_cfg_frozen_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pend)) |-> $stable(act_fmt));

    assert_cfg_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> ($stable(act_fmt) && $stable(act_exp_off)));
endmodule

bind rx_input_formatter rxif_checker #(.DATA_W(DATA_W), .OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_i      (out_i),
    .out_q      (out_q),
    .out_tag    (out_tag),
    .act_fmt    (act_fmt),
    .act_exp_en (act_exp_en),
    .act_exp_off(act_exp_off),
    .pend       (pend)
);

// File: tb/rx_input_formatter_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module rx_input_formatter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_exp_en = 1'b1;
    logic        cfg_exp_inv = 1'b0;
    logic [2:0]  cfg_exp_off = 3'd7;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [2:0]  in_exp = '0;
    logic        in_chan = 1'b0;
    logic        out_valid;
    logic [22:0] out_i, out_q;
    logic        out_tag;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    rx_input_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_exp_en(cfg_exp_en),
        .cfg_exp_inv(cfg_exp_inv), .cfg_exp_off(cfg_exp_off), .in_valid(in_valid),
        .in_data(in_data), .in_exp(in_exp), .in_chan(in_chan), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q), .out_tag(out_tag)
    );

    // Reference scaling, from R3, R4 and R5.
    function automatic logic [22:0] ref_scale(logic [15:0] d, logic [2:0] e,
                                              logic en, logic inv, logic [2:0] off);
        integer v, ee, s;
        v  = $signed(d) * 128;
        ee = en ? (inv ? 7 - int'(e) : int'(e)) : 0;
        s  = int'(off) - ee;
        if (s < 0) s = 0;
        v = v >>> s;
        return v[22:0];
    endfunction

    // Model state
    logic [1:0]  m_fmt;
    logic        m_en, m_inv;
    logic [2:0]  m_off;
    bit          m_pend = 0;
    logic [22:0] m_hold;
    bit          m_v = 0;
    logic [22:0] m_i = '0, m_q = '0;
    bit          m_tag = 0;

    always @(posedge clk) begin
        bit idle;
        logic [22:0] s;
        idle = !in_valid && !m_pend;
        s = ref_scale(in_data, in_exp, m_en, m_inv, m_off);
        m_v = 0;
        if (!rst_n) begin
            m_pend = 0; m_i = '0; m_q = '0; m_tag = 0;
        end else if (in_valid) begin
            if (m_fmt == 2'd2) begin
                if (!in_chan) begin m_pend = 1; m_hold = s; end
                else if (m_pend) begin m_pend = 0; m_v = 1; m_i = m_hold; m_q = s; m_tag = 0; end
            end else begin
                m_v = 1; m_i = s; m_q = '0;
                m_tag = (m_fmt == 2'd1) ? in_chan : 1'b0;
            end
        end
        if (!rst_n || idle) begin
            m_fmt = cfg_fmt; m_en = cfg_exp_en; m_inv = cfg_exp_inv; m_off = cfg_exp_off;
        end
    end

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            n_checks++;
            if (out_valid !== m_v || (m_v && (out_i !== m_i || out_q !== m_q || out_tag !== m_tag))) begin
                n_errors++;
                $display("FAIL %s: got v=%0b i=%h q=%h tag=%0b, expected v=%0b i=%h q=%h tag=%0b",
                         cur_req, out_valid, out_i, out_q, out_tag, m_v, m_i, m_q, m_tag);
            end
        end
    end

    task automatic check_val(string req, logic [22:0] act, logic [22:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s: got %h, expected %h", req, act, exp_v);
        end
    endtask

    task automatic send(logic [15:0] d, logic [2:0] e, logic c);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_exp = e; in_chan = c;
    endtask

    task automatic gap(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_cfg(logic [1:0] f, logic en, logic inv, logic [2:0] off);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_fmt = f; cfg_exp_en = en; cfg_exp_inv = inv; cfg_exp_off = off;
        gap(1);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check_val("R1", {22'd0, out_valid}, 23'd0);
        check_val("R1", out_i, 23'd0);
        check_val("R1", out_q, 23'd0);
        @(negedge clk) rst_n = 1'b1;
        gap(2);

        // R2 / R3: real format with exponent
        cur_req = "R3";
        send(16'h8000, 3'd7, 1'b0);
        @(posedge clk); #1;
        check_val("R3", out_i, 23'h400000);
        send(16'h0100, 3'd0, 1'b0);
        @(posedge clk); #1;
        check_val("R3", out_i, 23'h000100);
        cur_req = "R2";
        for (int k = 0; k < 24; k++) send(16'(k * 4099 + 17), 3'(k), 1'(k));
        gap(2);
        cur_req = "R10";
        for (int k = 0; k < 10; k++) begin send(16'(k * 777), 3'(k + 3), 1'b0); gap(k % 3); end
        gap(1);

        // R4: exponent bypass
        cur_req = "R4";
        set_cfg(2'd0, 1'b0, 1'b0, 3'd3);
        send(16'h1234, 3'd7, 1'b0);
        @(posedge clk); #1;
        check_val("R4", out_i, 23'(32'sh1234 * 16));
        for (int k = 0; k < 8; k++) send(16'(16'hF000 + k * 301), 3'(k), 1'b0);
        set_cfg(2'd0, 1'b0, 1'b0, 3'd0);
        for (int k = 0; k < 4; k++) send(16'(k * 9001), 3'(k), 1'b0);

        // R5: invert
        cur_req = "R5";
        set_cfg(2'd0, 1'b1, 1'b1, 3'd7);
        send(16'hFFFF, 3'd7, 1'b0);
        @(posedge clk); #1;
        check_val("R5", out_i, 23'h7FFFFF);
        for (int k = 0; k < 8; k++) send(16'(16'h8001 + k * 5003), 3'(k), 1'b0);
        set_cfg(2'd3, 1'b1, 1'b0, 3'd4);
        cur_req = "R2";
        for (int k = 0; k < 8; k++) send(16'(k * 1234 + 5), 3'(k), 1'b1);

        // R6: two-channel real
        cur_req = "R6";
        set_cfg(2'd1, 1'b1, 1'b0, 3'd5);
        send(16'h4000, 3'd2, 1'b1);
        @(posedge clk); #1;
        check_val("R6", {22'd0, out_tag}, 23'd1);
        for (int k = 0; k < 16; k++) send(16'(k * 3331), 3'(k), 1'(k));

        // R7: complex pairs
        cur_req = "R7";
        set_cfg(2'd2, 1'b1, 1'b0, 3'd7);
        send(16'h0010, 3'd0, 1'b0);
        send(16'h0020, 3'd1, 1'b1);
        @(posedge clk); #1;
        check_val("R7", out_i, 23'h000010);
        check_val("R7", out_q, 23'h000040);
        for (int k = 0; k < 8; k++) begin
            send(16'(k * 2111), 3'(k), 1'b0);
            if (k % 2 == 1) gap(1);
            send(16'(k * 613 + 1), 3'(7 - k), 1'b1);
        end
        gap(1);

        // R8: orphan Q and replaced I
        cur_req = "R8";
        send(16'h7777, 3'd0, 1'b1);
        @(posedge clk); #1;
        check_val("R8", {22'd0, out_valid}, 23'd0);
        send(16'h0001, 3'd0, 1'b0);
        send(16'h0002, 3'd0, 1'b0);
        send(16'h0003, 3'd0, 1'b1);
        @(posedge clk); #1;
        check_val("R8", out_i, 23'h000002);
        gap(1);

        // R9: configuration change while an I word is held
        cur_req = "R9";
        send(16'h0100, 3'd0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_fmt = 2'd0; cfg_exp_off = 3'd0;
        gap(2);
        send(16'h0200, 3'd0, 1'b1);
        @(posedge clk); #1;
        check_val("R9", out_q, 23'h000200);
        gap(2);
        send(16'h0004, 3'd0, 1'b0);
        @(posedge clk); #1;
        check_val("R9", out_i, 23'h000200);
        check_val("R9", out_q, 23'h000000);
        gap(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule